// File: doc/BRIEF.md
# Delayed-Read Prefetch Controller

This block sits on the target side of a two-port bus bridge and turns incoming read requests into delayed reads. When the initiator presents a read, the block always answers with retry. It latches the request and hands a forwarding request to the master on the far side. That forwarding request carries a start DWORD address, a DWORD count and byte enables. The block counts the DWORDs that come back. Once all of them are queued, a repeat of the same request is answered with a hit that reports how many DWORDs may be delivered. For a single-DWORD read, the hit also says to disconnect the initiator after the first DWORD.

The block decides how to fetch from the command code and from a prefetchable address window. Speculative reads fetch several DWORDs with every byte lane enabled. Exact reads fetch one DWORD with the initiator's own lanes. A speculative fetch is cut short so that it never runs past a 4 KB address boundary and never asks for more DWORDs than the buffer has free. Only one delayed read is outstanding at a time.

Top module: `bridge_dread_ctl`

## Requirements
- R1: Commands 1110 (read line) and 1100 (read multiple) are always speculative. Command 0110 (memory read) is speculative only when base <= address <= limit and base <= limit. Addresses are DWORD addresses.
- R2: Command 0010 (I/O read), command 1010 (configuration read) and 0110 outside the window are exact. Their forward count is 1 and their fwd_be_n equals the request's req_be_n. The later hit asserts rsp_single with rsp_cnt = 1.
- R3: A speculative forward drives fwd_be_n = 4'b0000 (active-low, so all lanes enabled). Its hit leaves rsp_single at 0.
- R4: The base speculative length is 8 DWORDs for 0110 and 1110 and 16 DWORDs for 1100.
- R5: A speculative count is the smallest of the base length, the DWORDs left before the next 4 KB boundary (1024 - address[9:0]) and buf_free.
- R6: With buf_free = 0, a read arriving while the block is idle is answered with retry, no forward is raised, and nothing is latched.
- R7: A read arriving while the block is idle is answered with rsp_retry in the following cycle. fwd_valid rises in that same cycle with fwd_addr equal to the request address. fwd_valid and the forward fields then hold until a cycle with fwd_ready.
- R8: Until the forwarded DWORDs (counted by dat_valid) are all queued, a repeat of the pending request (same cmd, address and req_be_n) is answered with retry. After they are queued, the repeat gets rsp_hit with rsp_cnt equal to the forward count, and the block returns to idle.
- R9: While a read is outstanding, a request that differs from the pending one is answered with retry. It is not latched, and the pending read completes unchanged.
- R10: A request whose command is not one of the five read codes gets neither retry nor hit and starts no forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe for an initiator request |
| req_cmd | input | 4 | Command code |
| req_addr | input | AW | DWORD address |
| req_be_n | input | 4 | Active-low byte enables |
| pf_base | input | AW | Prefetchable window base (DWORD) |
| pf_limit | input | AW | Prefetchable window limit (DWORD) |
| buf_free | input | FREE_W | Free buffer space in DWORDs |
| rsp_retry | output | 1 | Answer the initiator with retry |
| rsp_hit | output | 1 | Queued data is ready for this request |
| rsp_cnt | output | CW | DWORDs available on a hit |
| rsp_single | output | 1 | Disconnect after the first DWORD |
| fwd_valid | output | 1 | Forwarding request to the far-side master |
| fwd_ready | input | 1 | Far-side master accepts the forward |
| fwd_addr | output | AW | Forward start DWORD address |
| fwd_cnt | output | CW | Forward DWORD count |
| fwd_be_n | output | 4 | Forward byte enables (active-low) |
| dat_valid | input | 1 | One returned DWORD has been queued |

## Verification
The assertions assume that dat_valid pulses only while a forward has been accepted and is still short of its count. They also assume that req_valid lasts a single cycle per request. The bench respects both. It raises dat_valid exactly as many times as the checked forward count, and only after the fwd_ready handshake. Every request it drives is a one-cycle pulse, with a quiet cycle after it. Window bounds, addresses and free space are drawn at random, with pages weighted toward their ends so that the boundary cap is reached often.

// File: rtl/bridge_dread_ctl.sv
module bridge_dread_ctl #(
  parameter int AW      = 30,
  parameter int LINE_DW = 8,
  parameter int PAGE_DW = 1024,
  parameter int FREE_W  = 8,
  localparam int MAX_DW = 2 * LINE_DW,
  localparam int CW     = $clog2(MAX_DW + 1),
  localparam int PW     = $clog2(PAGE_DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [AW-1:0]     req_addr,
  input  logic [3:0]        req_be_n,
  input  logic [AW-1:0]     pf_base,
  input  logic [AW-1:0]     pf_limit,
  input  logic [FREE_W-1:0] buf_free,
  output logic              rsp_retry,
  output logic              rsp_hit,
  output logic [CW-1:0]     rsp_cnt,
  output logic              rsp_single,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [AW-1:0]     fwd_addr,
  output logic [CW-1:0]     fwd_cnt,
  output logic [3:0]        fwd_be_n,
  input  logic              dat_valid
);
  localparam logic [3:0] C_IORD = 4'b0010, C_CFGRD = 4'b1010, C_MRD = 4'b0110,
                         C_MRL = 4'b1110, C_MRM = 4'b1100;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;
  st_t st;

  logic [3:0]    p_cmd, p_be_n;
  logic          p_pref;
  logic [CW-1:0] got;

  wire is_read = req_cmd inside {C_IORD, C_CFGRD, C_MRD, C_MRL, C_MRM};
  wire in_win  = (pf_base <= pf_limit) && (req_addr >= pf_base) && (req_addr <= pf_limit);
  wire is_pref = (req_cmd == C_MRL) || (req_cmd == C_MRM) || (req_cmd == C_MRD && in_win);
  wire match   = (p_cmd == req_cmd) && (fwd_addr == req_addr) && (p_be_n == req_be_n);

  logic [31:0] base_len, page_left, len;
  always_comb begin
    base_len  = (req_cmd == C_MRM) ? 32'(MAX_DW) : 32'(LINE_DW);
    page_left = 32'(PAGE_DW) - 32'(req_addr[PW-1:0]);
    len       = base_len;
    if (page_left < len) len = page_left;
    if (32'(buf_free) < len) len = 32'(buf_free);
    if (!is_pref) len = 32'd1;
  end

  assign fwd_valid = (st == S_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      rsp_retry  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_cnt    <= '0;
      rsp_single <= 1'b0;
      p_cmd      <= '0;
      p_be_n     <= '0;
      p_pref     <= 1'b0;
      fwd_addr   <= '0;
      fwd_cnt    <= '0;
      fwd_be_n   <= '0;
      got        <= '0;
    end else begin
      rsp_retry <= 1'b0;
      rsp_hit   <= 1'b0;
      if (req_valid && is_read) begin
        case (st)
          S_IDLE: begin
            rsp_retry <= 1'b1;
            if (buf_free != '0) begin
              p_cmd    <= req_cmd;
              p_be_n   <= req_be_n;
              p_pref   <= is_pref;
              fwd_addr <= req_addr;
              fwd_cnt  <= CW'(len);
              fwd_be_n <= is_pref ? 4'b0000 : req_be_n;
              got      <= '0;
              st       <= S_ISSUE;
            end
          end
          S_DONE: begin
            if (match) begin
              rsp_hit    <= 1'b1;
              rsp_cnt    <= got;
              rsp_single <= ~p_pref;
              st         <= S_IDLE;
            end else begin
              rsp_retry <= 1'b1;
            end
          end
          default: rsp_retry <= 1'b1;
        endcase
      end
      if (st == S_ISSUE && fwd_ready) st <= S_WAIT;
      if (st == S_WAIT && dat_valid) begin
        got <= got + CW'(1);
        if (got + CW'(1) == fwd_cnt) st <= S_DONE;
      end
    end
  end

  p_lanes_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_cnt > CW'(1) |-> fwd_be_n == 4'b0000);
  p_page_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_cnt != '0 && fwd_cnt <= CW'(MAX_DW)
                  && 32'(fwd_addr[PW-1:0]) + 32'(fwd_cnt) <= 32'(PAGE_DW));
  p_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && is_read && st == S_IDLE && buf_free == '0 |=> !fwd_valid && rsp_retry);
  p_fwd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_cnt) && $stable(fwd_be_n));
  p_one_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_retry && rsp_hit));
  p_hit_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_cnt == fwd_cnt);
  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit && rsp_single |-> rsp_cnt == CW'(1));
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !is_read |=> !rsp_retry && !rsp_hit);
endmodule

// File: tb/bridge_dread_ctl_tb.sv
`timescale 1ns/1ps
module bridge_dread_ctl_tb;
  localparam int AW = 30, FREE_W = 8, CW = 5;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, fwd_ready = 0, dat_valid = 0;
  logic [3:0] req_cmd = 0, req_be_n = 0;
  logic [AW-1:0] req_addr = 0, pf_base = 0, pf_limit = 0;
  logic [FREE_W-1:0] buf_free = 0;
  logic rsp_retry, rsp_hit, rsp_single, fwd_valid;
  logic [CW-1:0] rsp_cnt, fwd_cnt;
  logic [AW-1:0] fwd_addr;
  logic [3:0] fwd_be_n;

  bridge_dread_ctl u_dut (.*);

  int nchk = 0, nfail = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_rd(input logic [3:0] c);
    return c inside {4'b0010, 4'b1010, 4'b0110, 4'b1110, 4'b1100};
  endfunction

  function automatic bit exp_pref(input logic [3:0] c, input logic [AW-1:0] a, b, l);
    if (c == 4'b1110 || c == 4'b1100) return 1;
    if (c == 4'b0110) return (b <= l) && (a >= b) && (a <= l);
    return 0;
  endfunction

  function automatic int exp_len(input logic [3:0] c, input logic [AW-1:0] a, b, l, input int fr);
    int n, pl;
    if (!exp_pref(c, a, b, l)) return 1;
    n  = (c == 4'b1100) ? 16 : 8;
    pl = 1024 - int'(a[9:0]);
    if (pl < n) n = pl;
    if (fr < n) n = fr;
    return n;
  endfunction

  task automatic send(input logic [3:0] c, input logic [AW-1:0] a, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_cmd = c; req_addr = a; req_be_n = be;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic txn(input logic [3:0] c, input logic [AW-1:0] a, input logic [3:0] be,
                     input logic [AW-1:0] b, l, input int fr);
    bit pf;
    int n;
    pf = exp_pref(c, a, b, l);
    n  = exp_len(c, a, b, l, fr);
    @(negedge clk);
    pf_base = b; pf_limit = l; buf_free = FREE_W'(fr);
    send(c, a, be);
    if (!is_rd(c)) begin
      check(!rsp_retry && !rsp_hit && !fwd_valid, "R10 non-read ignored", {rsp_retry, rsp_hit, fwd_valid}, 0);
      return;
    end
    check(rsp_retry && !rsp_hit, "R7 first request retried", rsp_retry, 1);
    if (fr == 0) begin
      check(!fwd_valid, "R6 no forward on zero free space", fwd_valid, 0);
      return;
    end
    check(fwd_valid && fwd_addr == a, "R7 forward address", fwd_addr, a);
    check(fwd_cnt == CW'(n), pf ? "R5 speculative count" : "R2 exact count", fwd_cnt, n);
    check(fwd_be_n == (pf ? 4'b0000 : be), pf ? "R3 lanes forced" : "R2 lanes forwarded", fwd_be_n, pf ? 0 : be);
    @(negedge clk);
    check(fwd_valid && fwd_cnt == CW'(n), "R7 forward held without ready", fwd_valid, 1);
    fwd_ready = 1;
    @(negedge clk);
    fwd_ready = 0;
    check(!fwd_valid, "R7 forward drops after ready", fwd_valid, 0);
    send(c, a, be);
    check(rsp_retry && !rsp_hit, "R8 repeat retried while fetching", rsp_hit, 0);
    send(c, a + 1, be);
    check(rsp_retry && !fwd_valid, "R9 mismatch retried, not latched", fwd_valid, 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dat_valid = 1;
      @(negedge clk);
      dat_valid = 0;
    end
    send(c, a, be ^ 4'b0001);
    check(rsp_retry && !rsp_hit, "R9 mismatch retried after data", rsp_hit, 0);
    send(c, a, be);
    check(rsp_hit && !rsp_retry, "R8 repeat hits after data", rsp_hit, 1);
    check(rsp_cnt == CW'(n), "R8 hit count", rsp_cnt, n);
    check(rsp_single == !pf, pf ? "R3 no early disconnect" : "R2 disconnect after first", rsp_single, !pf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, b, l;
    logic [3:0] c;
    int fr;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check(!rsp_retry && !rsp_hit && !fwd_valid, "R7 reset state quiet", {rsp_retry, rsp_hit, fwd_valid}, 0);
    rst_n = 1;
    // R1 / R4 directed
    txn(4'b0110, 30'h100, 4'hA, 30'h100, 30'h200, 40);   // window at base: 8
    txn(4'b0110, 30'h200, 4'hA, 30'h100, 30'h200, 40);   // window at limit: 8
    txn(4'b0110, 30'h201, 4'hA, 30'h100, 30'h200, 40);   // outside: exact R2
    txn(4'b0110, 30'h150, 4'h3, 30'h200, 30'h100, 40);   // base>limit: exact R1
    txn(4'b1110, 30'h50,  4'h5, 30'h0,   30'h0,   40);   // R4 line: 8
    txn(4'b1100, 30'h50,  4'h5, 30'h0,   30'h0,   40);   // R4 multiple: 16
    txn(4'b0010, 30'h120, 4'hE, 30'h0,   30'hFFF, 40);   // I/O exact R2
    txn(4'b1010, 30'h120, 4'h7, 30'h0,   30'hFFF, 40);   // config exact R2
    // R5 caps
    txn(4'b1100, 30'h3FC, 4'h0, 30'h0, 30'h0, 40);       // 4 left
    txn(4'b1110, 30'h7FF, 4'h0, 30'h0, 30'h0, 40);       // 1 left
    txn(4'b1100, 30'h10,  4'h0, 30'h0, 30'h0, 3);        // free 3
    // R6 / R10
    txn(4'b1100, 30'h10,  4'h0, 30'h0, 30'h0, 0);
    txn(4'b0111, 30'h10,  4'h0, 30'h0, 30'h0, 40);
    txn(4'b0110, 30'h10,  4'h0, 30'h0, 30'hFF, 40);      // idle after the above
    for (int k = 0; k < 300; k++) begin
      case ($urandom_range(0, 6))
        0: c = 4'b0010; 1: c = 4'b1010; 2, 3: c = 4'b0110;
        4: c = 4'b1110; 5: c = 4'b1100; default: c = 4'($urandom);
      endcase
      a = AW'($urandom);
      if ($urandom_range(0, 2) == 0) a[9:0] = 10'h3F0 | 10'($urandom_range(0, 15));
      b = a - AW'($urandom_range(0, 40)) + AW'($urandom_range(0, 20));
      l = a + AW'($urandom_range(0, 40)) - AW'($urandom_range(0, 20));
      fr = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 24);
      txn(c, a, 4'($urandom), b, l, fr);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule